// File: doc/BRIEF.md
# CAM Device Selection and Result Status

This block decides, for one device of a multi-chip content-addressable memory array, whether the device is selected in each access cycle. It keeps that device's sticky result status: the match, multiple-match and full flags, the captured page:active address, and two validation bits that record which kind of cycle produced the captured address. A device can be selected in two ways. One is either of two active-low chip-select inputs. The other is a device-select register whose value equals the device page address while that register's active-low enable bit is low.

An access cycle is framed by the active-low enable `en_n`. A small state machine has two states, IDLE and ACTIVE. The transition START (IDLE to ACTIVE) is taken on the first clock edge at which `en_n` is sampled low. On that edge the cycle kind, the selection decision and all cycle inputs are latched. The transition COMMIT (ACTIVE to IDLE) is taken on the first clock edge at which `en_n` is sampled high again. On that edge the status word and the device-select register are updated from the latched request.

A compare cycle that passes the device by, because the device is not selected, still clears any earlier match. This keeps a stale hit from winning priority resolution across the array. The compare array and the bus drivers are outside this block.

Top module: `cam_sel_status`

## Requirements
- R1: After reset the status word reads 0x00FFF with the default widths. Its fields are: match flag 0, multiple-match flag 0, full flag 0, page:active address all ones, validation bits 00. The device-select enable bit resets high, so the register selects nothing.
- R2: `sel` is 1 whenever `cs1_n` or `cs2_n` is low. The selection value used by a cycle is the value of `sel` on the START edge.
- R3: With both chip selects high, `sel` is 1 only when two conditions hold: the device-select value (bits PAGE_W-1:0) equals `page`, and the device-select enable bit (bit PAGE_W, active low) is 0. Otherwise `sel` is 0.
- R4: A cycle of kind 4 (device-select write) loads `dsel_wdata` into the device-select register at COMMIT, whether or not the device is selected. The status word is left unchanged.
- R5: A selected compare (kind 1) with `hit`=1 does the following at COMMIT. It sets the match flag to 1, the multiple-match flag to `multi`, the full flag to `full`, the address to {`page`,`hit_addr`} and the validation bits to 01.
- R6: A selected compare with `hit`=0 does the following at COMMIT. It sets the match and multiple-match flags to 0, the address to all ones, the validation bits to 00 and the full flag to `full`.
- R7: A compare while the device is not selected does the following at COMMIT. It clears the match and multiple-match flags, sets the address to all ones and the validation bits to 00, and leaves the full flag unchanged.
- R8: A selected next-free cycle (kind 2) sets the address to {`page`,`nf_addr`} and the validation bits to 10. All flags are unchanged.
- R9: A selected random read/write cycle (kind 3) sets the address to {`page`,`ra_addr`} and the validation bits to 11. All flags are unchanged.
- R10: A no-operation cycle (kind 0, or kinds 5 to 7) leaves the status unchanged. So does any cycle of kind 2 or 3 while the device is not selected.
- R11: The status word changes only on the COMMIT edge. It holds its value for every cycle that `en_n` stays low, however long the low phase is. Status bit layout, from least significant bit: active address (AA_W bits), page (PAGE_W bits), match flag, multiple-match flag, full flag, then validation bits in the top two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_n | input | 1 | Active-low cycle enable; low phase frames one cycle |
| cs1_n | input | 1 | Active-low chip select 1 |
| cs2_n | input | 1 | Active-low chip select 2 |
| kind | input | 3 | Cycle kind: 0 nop, 1 compare, 2 next free, 3 random access, 4 device-select write |
| page | input | PAGE_W | Device page address |
| hit | input | 1 | Compare produced a match in this device |
| multi | input | 1 | Compare produced more than one match |
| full | input | 1 | Device has no free location |
| hit_addr | input | AA_W | Highest-priority matching location |
| nf_addr | input | AA_W | Next free location |
| ra_addr | input | AA_W | Random access location |
| dsel_wdata | input | PAGE_W+1 | Device-select write data; top bit is the active-low enable |
| sel | output | 1 | Device is selected (combinational) |
| status | output | AA_W+PAGE_W+5 | Status register image |

## Verification
`sel` responds combinationally, so the bench checks it on the falling clock edge after it drives the inputs. The status word and the device-select register are both due one rising edge after `en_n` returns high. For status, the driver pushes the value the requirements predict into a queue. The monitor compares it on the falling edge that follows the COMMIT edge, and for a device-select write it then checks `sel` in the next cycle. On every falling edge while `en_n` is low, including extended low phases, the driver also checks that the status still equals the value from the previous cycle.

// File: rtl/cam_sel_pkg.sv
package cam_sel_pkg;

    typedef enum logic [2:0] {
        K_NOP   = 3'd0,
        K_CMP   = 3'd1,
        K_NFREE = 3'd2,
        K_RAND  = 3'd3,
        K_DSEL  = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        VB_NONE  = 2'b00,
        VB_MATCH = 2'b01,
        VB_NFREE = 2'b10,
        VB_RAND  = 2'b11
    } vb_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_ACTIVE = 1'b1
    } cyc_state_e;

endpackage

// File: rtl/cam_dsel_unit.sv
module cam_dsel_unit #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1_n,
    input  logic              cs2_n,
    input  logic [PAGE_W-1:0] page,
    input  logic              wr_en,
    input  logic [PAGE_W:0]   wr_data,
    output logic              sel
);
    localparam int EN_BIT = PAGE_W;

    logic [PAGE_W:0] dsel_q;
    logic            reg_hit;
    logic            cs_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsel_q <= {1'b1, {PAGE_W{1'b0}}};
        end else if (wr_en) begin
            dsel_q <= wr_data;
        end
    end

    always_comb begin
        cs_hit  = !cs1_n || !cs2_n;
        reg_hit = (dsel_q[PAGE_W-1:0] == page) && !dsel_q[EN_BIT];
        sel     = cs_hit || reg_hit;
    end

    // R3: a disabled device-select register never selects on its own
    p_dsel_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n && cs2_n && dsel_q[EN_BIT]) |-> !sel);

endmodule

// File: rtl/cam_cyc_fsm.sv
module cam_cyc_fsm
    import cam_sel_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int AA_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_n,
    input  logic [2:0]      kind_in,
    input  logic            sel_in,
    input  logic            hit_in,
    input  logic            multi_in,
    input  logic            full_in,
    input  logic [AA_W-1:0] hit_addr_in,
    input  logic [AA_W-1:0] nf_addr_in,
    input  logic [AA_W-1:0] ra_addr_in,
    input  logic [PAGE_W:0] wdata_in,
    output logic            commit,
    output kind_e           kind_q,
    output logic            sel_q,
    output logic            hit_q,
    output logic            multi_q,
    output logic            full_q,
    output logic [AA_W-1:0] hit_addr_q,
    output logic [AA_W-1:0] nf_addr_q,
    output logic [AA_W-1:0] ra_addr_q,
    output logic [PAGE_W:0] wdata_q
);
    cyc_state_e state_q, state_d;
    logic       start;
    kind_e      kind_dec;

    always_comb begin
        case (kind_in)
            3'd1:    kind_dec = K_CMP;
            3'd2:    kind_dec = K_NFREE;
            3'd3:    kind_dec = K_RAND;
            3'd4:    kind_dec = K_DSEL;
            default: kind_dec = K_NOP;
        endcase
    end

    // next-state logic: START on en_n low, COMMIT on en_n high
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (!en_n) state_d = S_ACTIVE;
            S_ACTIVE: if (en_n)  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        start  = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            S_IDLE:   start  = !en_n;
            S_ACTIVE: commit = en_n;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= K_NOP;
            sel_q      <= 1'b0;
            hit_q      <= 1'b0;
            multi_q    <= 1'b0;
            full_q     <= 1'b0;
            hit_addr_q <= '0;
            nf_addr_q  <= '0;
            ra_addr_q  <= '0;
            wdata_q    <= '0;
        end else if (start) begin
            kind_q     <= kind_dec;
            sel_q      <= sel_in;
            hit_q      <= hit_in;
            multi_q    <= multi_in;
            full_q     <= full_in;
            hit_addr_q <= hit_addr_in;
            nf_addr_q  <= nf_addr_in;
            ra_addr_q  <= ra_addr_in;
            wdata_q    <= wdata_in;
        end
    end

    // R11: a commit only ever follows a cycle in which enable was low
    p_commit_after_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (en_n && $past(!en_n)));

endmodule

// File: rtl/cam_status_reg.sv
module cam_status_reg
    import cam_sel_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int AA_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  kind_e                    kind_q,
    input  logic                     sel_q,
    input  logic                     hit_q,
    input  logic                     multi_q,
    input  logic                     full_q,
    input  logic [AA_W-1:0]          hit_addr_q,
    input  logic [AA_W-1:0]          nf_addr_q,
    input  logic [AA_W-1:0]          ra_addr_q,
    input  logic [PAGE_W-1:0]        page,
    output logic [AA_W+PAGE_W+4:0]   status
);
    localparam int ADDR_W = AA_W + PAGE_W;

    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              mf_q, mf_d;
    logic              mm_q, mm_d;
    logic              ff_q, ff_d;
    vb_e               vb_q, vb_d;

    always_comb begin
        addr_d = addr_q;
        mf_d   = mf_q;
        mm_d   = mm_q;
        ff_d   = ff_q;
        vb_d   = vb_q;
        if (commit) begin
            unique case (kind_q)
                K_CMP: begin
                    if (sel_q) begin
                        mf_d   = hit_q;
                        mm_d   = hit_q && multi_q;
                        ff_d   = full_q;
                        addr_d = hit_q ? {page, hit_addr_q} : {ADDR_W{1'b1}};
                        vb_d   = hit_q ? VB_MATCH : VB_NONE;
                    end else begin
                        mf_d   = 1'b0;
                        mm_d   = 1'b0;
                        addr_d = {ADDR_W{1'b1}};
                        vb_d   = VB_NONE;
                    end
                end
                K_NFREE: begin
                    if (sel_q) begin
                        addr_d = {page, nf_addr_q};
                        vb_d   = VB_NFREE;
                    end
                end
                K_RAND: begin
                    if (sel_q) begin
                        addr_d = {page, ra_addr_q};
                        vb_d   = VB_RAND;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= {ADDR_W{1'b1}};
            mf_q   <= 1'b0;
            mm_q   <= 1'b0;
            ff_q   <= 1'b0;
            vb_q   <= VB_NONE;
        end else begin
            addr_q <= addr_d;
            mf_q   <= mf_d;
            mm_q   <= mm_d;
            ff_q   <= ff_d;
            vb_q   <= vb_d;
        end
    end

    assign status = {vb_q, ff_q, mm_q, mf_q, addr_q};

    // R11: outside a commit the status image holds
    p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(status));

    // R7: a compare that passes the device by leaves no match behind
    p_desel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind_q == K_CMP && !sel_q) |=> (!mf_q && !mm_q && vb_q == VB_NONE));

    // R5: a selected hit reports a match-sourced address
    p_hit_report_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind_q == K_CMP && sel_q && hit_q) |=> (mf_q && vb_q == VB_MATCH));

    // R5, R6: a match-sourced address always comes with the match flag set
    p_vb_needs_mf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_q == VB_MATCH) |-> mf_q);

    // R6: multiple match is never reported without a match
    p_mm_needs_mf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mm_q |-> mf_q);

endmodule

// File: rtl/cam_sel_status.sv
module cam_sel_status
    import cam_sel_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int AA_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_n,
    input  logic                   cs1_n,
    input  logic                   cs2_n,
    input  logic [2:0]             kind,
    input  logic [PAGE_W-1:0]      page,
    input  logic                   hit,
    input  logic                   multi,
    input  logic                   full,
    input  logic [AA_W-1:0]        hit_addr,
    input  logic [AA_W-1:0]        nf_addr,
    input  logic [AA_W-1:0]        ra_addr,
    input  logic [PAGE_W:0]        dsel_wdata,
    output logic                   sel,
    output logic [AA_W+PAGE_W+4:0] status
);
    logic            commit;
    kind_e           kind_q;
    logic            sel_q;
    logic            hit_q;
    logic            multi_q;
    logic            full_q;
    logic [AA_W-1:0] hit_addr_q;
    logic [AA_W-1:0] nf_addr_q;
    logic [AA_W-1:0] ra_addr_q;
    logic [PAGE_W:0] wdata_q;
    logic            dsel_wr;

    assign dsel_wr = commit && (kind_q == K_DSEL);

    cam_dsel_unit #(.PAGE_W(PAGE_W)) u_dsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs1_n   (cs1_n),
        .cs2_n   (cs2_n),
        .page    (page),
        .wr_en   (dsel_wr),
        .wr_data (wdata_q),
        .sel     (sel)
    );

    cam_cyc_fsm #(.PAGE_W(PAGE_W), .AA_W(AA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_n        (en_n),
        .kind_in     (kind),
        .sel_in      (sel),
        .hit_in      (hit),
        .multi_in    (multi),
        .full_in     (full),
        .hit_addr_in (hit_addr),
        .nf_addr_in  (nf_addr),
        .ra_addr_in  (ra_addr),
        .wdata_in    (dsel_wdata),
        .commit      (commit),
        .kind_q      (kind_q),
        .sel_q       (sel_q),
        .hit_q       (hit_q),
        .multi_q     (multi_q),
        .full_q      (full_q),
        .hit_addr_q  (hit_addr_q),
        .nf_addr_q   (nf_addr_q),
        .ra_addr_q   (ra_addr_q),
        .wdata_q     (wdata_q)
    );

    cam_status_reg #(.PAGE_W(PAGE_W), .AA_W(AA_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .kind_q     (kind_q),
        .sel_q      (sel_q),
        .hit_q      (hit_q),
        .multi_q    (multi_q),
        .full_q     (full_q),
        .hit_addr_q (hit_addr_q),
        .nf_addr_q  (nf_addr_q),
        .ra_addr_q  (ra_addr_q),
        .page       (page),
        .status     (status)
    );

    // R4: a device-select write never disturbs the status image
    p_dsel_wr_keeps_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dsel_wr |=> $stable(status));

endmodule

// File: tb/cam_sel_status_bench.sv
`timescale 1ns/1ps
module cam_sel_status_bench;
    localparam int PAGE_W = 4;
    localparam int AA_W   = 8;
    localparam int SW     = AA_W + PAGE_W + 5;
    localparam int ADDR_W = AA_W + PAGE_W;
    localparam logic [PAGE_W-1:0] PG = 4'hA;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_n = 1'b1;
    logic              cs1_n = 1'b1;
    logic              cs2_n = 1'b1;
    logic [2:0]        kind = 3'd0;
    logic [PAGE_W-1:0] page = PG;
    logic              hit = 1'b0;
    logic              multi = 1'b0;
    logic              full = 1'b0;
    logic [AA_W-1:0]   hit_addr = '0;
    logic [AA_W-1:0]   nf_addr = '0;
    logic [AA_W-1:0]   ra_addr = '0;
    logic [PAGE_W:0]   dsel_wdata = '0;
    logic              sel;
    logic [SW-1:0]     status;

    always #2.5 clk = ~clk;

    cam_sel_status #(.PAGE_W(PAGE_W), .AA_W(AA_W)) u_cam_sel_status (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
        .kind(kind), .page(page), .hit(hit), .multi(multi), .full(full),
        .hit_addr(hit_addr), .nf_addr(nf_addr), .ra_addr(ra_addr),
        .dsel_wdata(dsel_wdata), .sel(sel), .status(status)
    );

    typedef struct {
        string         tag;
        logic [SW-1:0] word;
    } exp_t;

    exp_t          sb_q[$];
    event          chk_ev;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    // reference model state
    logic [1:0]        m_vb = 2'b00;
    logic              m_ff = 1'b0, m_mm = 1'b0, m_mf = 1'b0;
    logic [ADDR_W-1:0] m_addr = '1;
    logic [PAGE_W:0]   m_dsel = {1'b1, {PAGE_W{1'b0}}};

    function automatic logic [SW-1:0] m_word();
        return {m_vb, m_ff, m_mm, m_mf, m_addr};
    endfunction

    function automatic logic m_sel(logic c1, logic c2);
        return !c1 || !c2 || (m_dsel[PAGE_W-1:0] == PG && !m_dsel[PAGE_W]);
    endfunction

    task automatic chk(string tag, logic [SW-1:0] act, logic [SW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_sel(string tag, logic exp);
        @(negedge clk);
        chk(tag, {{(SW-1){1'b0}}, sel}, {{(SW-1){1'b0}}, exp});
    endtask

    // driver: runs one enable-framed cycle, pushes the predicted status
    task automatic run_cyc(string tag, logic [2:0] k, logic c1, logic c2,
                           logic h, logic mu, logic fu, logic [AA_W-1:0] ha,
                           logic [AA_W-1:0] na, logic [AA_W-1:0] ra,
                           logic [PAGE_W:0] wd, int nlow);
        logic   s;
        exp_t   it;
        logic [SW-1:0] prev;
        prev = m_word();
        s = m_sel(c1, c2);
        case (k)
            3'd1: begin
                if (s) begin
                    m_mf = h; m_mm = h & mu; m_ff = fu;
                    m_addr = h ? {PG, ha} : '1;
                    m_vb = h ? 2'b01 : 2'b00;
                end else begin
                    m_mf = 1'b0; m_mm = 1'b0; m_addr = '1; m_vb = 2'b00;
                end
            end
            3'd2: if (s) begin m_addr = {PG, na}; m_vb = 2'b10; end
            3'd3: if (s) begin m_addr = {PG, ra}; m_vb = 2'b11; end
            default: ;
        endcase
        it.tag = tag;
        it.word = m_word();
        sb_q.push_back(it);
        @(negedge clk);
        kind = k; cs1_n = c1; cs2_n = c2; hit = h; multi = mu; full = fu;
        hit_addr = ha; nf_addr = na; ra_addr = ra; dsel_wdata = wd;
        en_n = 1'b0;
        for (int i = 0; i < nlow; i++) begin
            @(negedge clk);
            chk({tag, " R11 hold"}, status, prev);
        end
        en_n = 1'b1;
        @(negedge clk);
        -> chk_ev;
        if (k == 3'd4) m_dsel = wd;
        cs1_n = 1'b1; cs2_n = 1'b1; kind = 3'd0;
    endtask

    // monitor: compares the design's status against the scoreboard
    initial begin
        forever begin
            @(chk_ev);
            if (sb_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL scoreboard empty: actual %h expected none", status);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, status, e.word);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status, {5'b0, {ADDR_W{1'b1}}});
        chk("R1 R3 reset dsel disabled", {{(SW-1){1'b0}}, sel}, '0);

        cs1_n = 1'b0; chk_sel("R2 cs1_n low", 1'b1);
        cs1_n = 1'b1; cs2_n = 1'b0; chk_sel("R2 cs2_n low", 1'b1);
        cs2_n = 1'b1; chk_sel("R2 both high", 1'b0);

        run_cyc("R5 selected hit", 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
                8'h35, 8'h00, 8'h00, '0, 2);
        run_cyc("R10 deselected random", 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                8'h00, 8'h00, 8'h44, '0, 1);
        run_cyc("R10 deselected next free", 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                8'h00, 8'h55, 8'h00, '0, 1);
        run_cyc("R5 hit no multi full", 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
                8'hC3, 8'h00, 8'h00, '0, 1);
        run_cyc("R7 deselected compare", 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
                8'h11, 8'h00, 8'h00, '0, 1);
        run_cyc("R6 selected miss", 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1,
                8'h22, 8'h00, 8'h00, '0, 1);
        run_cyc("R8 next free", 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
                8'h00, 8'h12, 8'h00, '0, 1);
        run_cyc("R9 random access", 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                8'h00, 8'h00, 8'h7E, '0, 1);
        run_cyc("R10 selected nop", 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
                8'h99, 8'h98, 8'h97, '0, 1);
        run_cyc("R10 kind 6 nop", 3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0,
                8'h66, 8'h00, 8'h00, '0, 1);

        run_cyc("R4 dsel write enable low", 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                8'h00, 8'h00, 8'h00, {1'b0, PG}, 1);
        chk_sel("R3 R4 dsel selects page", 1'b1);
        run_cyc("R5 hit via dsel", 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                8'h0F, 8'h00, 8'h00, '0, 3);
        run_cyc("R8 next free via dsel", 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                8'h00, 8'hA5, 8'h00, '0, 1);
        run_cyc("R4 dsel write enable high", 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
                8'h00, 8'h00, 8'h00, {1'b1, PG}, 1);
        chk_sel("R3 dsel enable high", 1'b0);
        run_cyc("R4 dsel write other page", 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                8'h00, 8'h00, 8'h00, {1'b0, 4'h5}, 1);
        chk_sel("R3 dsel other page", 1'b0);
        run_cyc("R7 compare after dsel off", 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                8'h01, 8'h00, 8'h00, '0, 1);
        run_cyc("R11 long low hit", 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                8'hE7, 8'h00, 8'h00, '0, 6);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule